// File: doc/BRIEF.md
# Synchronous Burst SRAM Front End

This block is the clocked control front end of a 36-bit-wide burst memory, placed over a small behavioural array whose depth is set by a parameter. The word is split into four 9-bit byte lanes. Each rising clock edge samples the address, write data, three chip enables, two address strobes, the burst-step input and the write controls. A burst starts when either strobe loads an external address. The block then forms the later addresses itself from a 2-bit counter. A pin picks the step order: interleaved or linear.

Read data flows straight from the array to the output with no output register. An output-enable input and a sleep input gate the output at once, without waiting for a clock edge. The module has no tri-state pins. An output-drive flag tells the enclosing logic when the data bus should be driven. While sleep is high, the block holds its state and writes nothing.

Top module: `sburst_sram`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block drops its selected state and clears the burst counter, so `drive_o` is low after reset is released until a new burst selects the device.
- R2: At an edge where `ctl_stb_n` is low, or where `cpu_stb_n` is low with `en1_n` low, the block loads `addr_i` as the burst start and clears the counter. The device becomes selected only when `en1_n`=0, `en2`=1 and `en3_n`=0. A deselected device drives nothing and writes nothing.
- R3: A low `cpu_stb_n` while `en1_n` is high is ignored: the address, the selected state and the output stay as they were.
- R4: The burst counter steps by one at an edge only when the device is selected, no strobe is taken, sleep is low and `step_n` is low. Otherwise the current address holds.
- R5: With `ilv_order`=1, the two low address bits are the start bits XOR the count. The upper address bits keep the start value.
- R6: With `ilv_order`=0, the two low address bits are the start bits plus the count, modulo 4. The upper bits keep the start value.
- R7: Lane k is `din_i[9k+8:9k]`. It is written at an edge when `lane_en_n`=0 and `lane_wr_n[k]`=0. Lanes whose bit is high keep their contents. With `lane_en_n`=1, the lane bits have no effect.
- R8: `all_wr_n`=0 writes all four lanes, whatever `lane_en_n` and `lane_wr_n` are.
- R9: A write and a burst step in the same cycle store the data at the address held before the step.
- R10: In a cycle where a strobe is taken, the write controls are ignored.
- R11: `drive_o` is high exactly when the device is selected, `out_en_n` is low and `sleep` is low. It follows `out_en_n` and `sleep` without a clock edge.
- R12: While `sleep` is high, no write happens, the burst state does not change and `drive_o` is low.
- R13: `dout_o` shows the word at the current burst address in the same cycle as the address changes, including data written at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep | input | 1 | Power-down request, active high |
| addr_i | input | ADDR_W | External burst start address |
| din_i | input | 36 | Write data, four 9-bit lanes |
| en1_n | input | 1 | First chip enable, active low |
| en2 | input | 1 | Second chip enable, active high |
| en3_n | input | 1 | Third chip enable, active low |
| cpu_stb_n | input | 1 | Processor-side address strobe, active low, qualified by `en1_n` |
| ctl_stb_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Write every lane, active low |
| lane_en_n | input | 1 | Enables per-lane writes, active low |
| lane_wr_n | input | 4 | Per-lane write selects, active low |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| ilv_order | input | 1 | 1 selects interleaved order, 0 selects linear order |
| dout_o | output | 36 | Flow-through read data |
| drive_o | output | 1 | High when the data bus is to be driven |

## Verification
Two functions can land on the same edge: a write to the current burst word and a step of the burst counter. If the counter moved first, the data would land one word late. The bench provokes this by filling a burst with global writes while stepping, and also at random across thousands of cycles. It judges the result by restarting the burst and reading every word back against a reference model. A second collision, a strobe arriving with a write request, is driven in a directed step and judged the same way by reading back.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes and the burst order encoding for the burst SRAM front end.
// Assumes a 2-bit burst counter and 9-bit byte lanes.
package sbs_pkg;
    localparam int CNT_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_ord_e;
endpackage

// File: rtl/sbs_addr_ctl.sv
`timescale 1ns/1ps
// Module: burst address control.
// Takes a burst start from either strobe, keeps the selected state, steps the
// 2-bit counter and forms the current address in the chosen order.
// Assumes ADDR_W >= 2. Sleep freezes all state.
module sbs_addr_ctl
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              en1_n,
    input  logic              en2,
    input  logic              en3_n,
    input  logic              cpu_stb_n,
    input  logic              ctl_stb_n,
    input  logic              step_n,
    input  logic              ilv_order,
    output logic              load,
    output logic              active,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int UP_W = ADDR_W - CNT_W;

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  low_bits;
    logic              sel_c;
    burst_ord_e        order;

    // Decode the three chip enables into one select term.
    assign sel_c = !en1_n && en2 && !en3_n;

    // A strobe is taken when awake; the processor strobe needs the first enable.
    assign load = !sleep && ((!cpu_stb_n && !en1_n) || !ctl_stb_n);

    // Load the start address or step the counter at the clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            active <= 1'b0;
        end else if (load) begin
            base_q <= addr_i;
            cnt_q  <= '0;
            active <= sel_c;
        end else if (!sleep && active && !step_n) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Pick the order from the mode pin.
    assign order = burst_ord_e'(ilv_order);

    // Form the low address bits in the selected order.
    always_comb begin
        if (order == ORD_INTERLEAVE) low_bits = base_q[CNT_W-1:0] ^ cnt_q;
        else                         low_bits = base_q[CNT_W-1:0] + cnt_q;
    end

    assign cur_addr = {base_q[ADDR_W-1:CNT_W], low_bits};

    // The upper part of the address is carried unchanged through the burst.
    logic [UP_W-1:0] up_unused;
    assign up_unused = base_q[ADDR_W-1:CNT_W];
endmodule

// File: rtl/sbs_wr_mask.sv
`timescale 1ns/1ps
// Module: per-lane write enable logic.
// Combines the global write and the per-lane write path into one enable per
// lane. Writes need a selected device, no strobe this cycle, and sleep low.
module sbs_wr_mask #(
    parameter int NLANES = 4
) (
    input  logic              active,
    input  logic              load,
    input  logic              sleep,
    input  logic              all_wr_n,
    input  logic              lane_en_n,
    input  logic [NLANES-1:0] lane_wr_n,
    output logic [NLANES-1:0] lane_we
);
    logic wr_ok;

    // A write may only happen on a selected, awake, non-strobe cycle.
    assign wr_ok = active && !load && !sleep;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        // Lane enable: the global write, or the lane path gated by its enable.
        assign lane_we[g] = wr_ok && (!all_wr_n || (!lane_en_n && !lane_wr_n[g]));
    end
endmodule

// File: rtl/sbs_array.sv
`timescale 1ns/1ps
// Module: behavioural lane-split storage array.
// Has one address, written per lane at the clock edge and read
// combinationally (flow-through). Has no reset; contents start unknown.
module sbs_array #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int NLANES = 4
) (
    input  logic                     clk,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NLANES-1:0]        lane_we,
    input  logic [LANE_W*NLANES-1:0] wdata,
    output logic [LANE_W*NLANES-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        // Store this lane's slice when its enable is set.
        always_ff @(posedge clk) begin
            if (lane_we[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        // Read this lane straight through to the output.
        assign rdata[g*LANE_W +: LANE_W] = cells[addr];
    end
endmodule

// File: rtl/sburst_sram.sv
`timescale 1ns/1ps
// Module: synchronous burst SRAM front end (top).
// Connects the burst address control, the lane write mask and the array.
// Read data is flow-through. drive_o stands in for the bus tri-state and
// reacts to out_en_n and sleep without a clock edge.
module sburst_sram #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int NLANES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sleep,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [LANE_W*NLANES-1:0] din_i,
    input  logic                     en1_n,
    input  logic                     en2,
    input  logic                     en3_n,
    input  logic                     cpu_stb_n,
    input  logic                     ctl_stb_n,
    input  logic                     step_n,
    input  logic                     all_wr_n,
    input  logic                     lane_en_n,
    input  logic [NLANES-1:0]        lane_wr_n,
    input  logic                     out_en_n,
    input  logic                     ilv_order,
    output logic [LANE_W*NLANES-1:0] dout_o,
    output logic                     drive_o
);
    logic              load;
    logic              active;
    logic [ADDR_W-1:0] cur_addr;
    logic [NLANES-1:0] lane_we;

    sbs_addr_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep     (sleep),
        .addr_i    (addr_i),
        .en1_n     (en1_n),
        .en2       (en2),
        .en3_n     (en3_n),
        .cpu_stb_n (cpu_stb_n),
        .ctl_stb_n (ctl_stb_n),
        .step_n    (step_n),
        .ilv_order (ilv_order),
        .load      (load),
        .active    (active),
        .cur_addr  (cur_addr)
    );

    sbs_wr_mask #(.NLANES(NLANES)) u_mask (
        .active    (active),
        .load      (load),
        .sleep     (sleep),
        .all_wr_n  (all_wr_n),
        .lane_en_n (lane_en_n),
        .lane_wr_n (lane_wr_n),
        .lane_we   (lane_we)
    );

    sbs_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .NLANES(NLANES)) u_arr (
        .clk     (clk),
        .addr    (cur_addr),
        .lane_we (lane_we),
        .wdata   (din_i),
        .rdata   (dout_o)
    );

    // Drive the bus only when selected, enabled and awake.
    assign drive_o = active && !out_en_n && !sleep;
endmodule

// File: rtl/sburst_sram_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for the burst SRAM front end, bound to the top.
// Observes ports and the nets between the control, mask and array blocks.
module sburst_sram_chk #(
    parameter int ADDR_W = 8,
    parameter int NLANES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep,
    input logic [ADDR_W-1:0] addr_i,
    input logic              en1_n,
    input logic              en2,
    input logic              en3_n,
    input logic              cpu_stb_n,
    input logic              ctl_stb_n,
    input logic              step_n,
    input logic              all_wr_n,
    input logic              ilv_order,
    input logic              load,
    input logic              active,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [NLANES-1:0] lane_we,
    input logic              drive_o
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !active);

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_stb_n && !sleep && !en1_n && en2 && !en3_n)
        |=> (active && cur_addr[ADDR_W-1:2] == $past(addr_i[ADDR_W-1:2])));

    // R3
    cpu_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_stb_n && en1_n && step_n)
        |=> ($stable(active) && ($stable(cur_addr) || !$stable(ilv_order))));

    // R4
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !load && step_n && !sleep)
        |=> ($stable(cur_addr) || !$stable(ilv_order)));

    // R8
    global_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_wr_n && active && !load && !sleep) |-> (&lane_we));

    // R10
    strobe_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (lane_we == '0));

    // R12
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (lane_we == '0 && !drive_o));

    // R12
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> $stable(active));
endmodule

bind sburst_sram sburst_sram_chk #(.ADDR_W(ADDR_W), .NLANES(NLANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep     (sleep),
    .addr_i    (addr_i),
    .en1_n     (en1_n),
    .en2       (en2),
    .en3_n     (en3_n),
    .cpu_stb_n (cpu_stb_n),
    .ctl_stb_n (ctl_stb_n),
    .step_n    (step_n),
    .all_wr_n  (all_wr_n),
    .ilv_order (ilv_order),
    .load      (load),
    .active    (active),
    .cur_addr  (cur_addr),
    .lane_we   (lane_we),
    .drive_o   (drive_o)
);

// File: tb/sburst_sram_test.sv
`timescale 1ns/1ps
// Bench: reference model plus directed corner cases and seeded random traffic.
module sburst_sram_test;
    localparam int AW = 8;
    localparam int LW = 9;
    localparam int NL = 4;
    localparam int WW = LW * NL;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n, sleep, en1_n, en2, en3_n, cpu_stb_n, ctl_stb_n;
    logic          step_n, all_wr_n, lane_en_n, out_en_n, ilv_order;
    logic [AW-1:0] addr_i;
    logic [WW-1:0] din_i, dout_o;
    logic [NL-1:0] lane_wr_n;
    logic          drive_o;

    always #2.5 clk = ~clk;

    sburst_sram #(.ADDR_W(AW), .LANE_W(LW), .NLANES(NL)) uut (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .addr_i(addr_i), .din_i(din_i),
        .en1_n(en1_n), .en2(en2), .en3_n(en3_n), .cpu_stb_n(cpu_stb_n),
        .ctl_stb_n(ctl_stb_n), .step_n(step_n), .all_wr_n(all_wr_n),
        .lane_en_n(lane_en_n), .lane_wr_n(lane_wr_n), .out_en_n(out_en_n),
        .ilv_order(ilv_order), .dout_o(dout_o), .drive_o(drive_o)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [WW-1:0] mem_m [DEPTH];
    logic [NL-1:0] vld   [DEPTH];
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;
    logic          m_act;

    // Expected address from start, count and order.
    function automatic logic [AW-1:0] calc_addr(input logic [AW-1:0] b,
                                                 input logic [1:0] c, input logic ilv);
        logic [1:0] lo;
        if (ilv) lo = b[1:0] ^ c;
        else     lo = 2'(b[1:0] + c);
        return {b[AW-1:2], lo};
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance the model by one clock edge using the inputs present now.
    task automatic model_edge();
        logic [AW-1:0] a;
        if (!rst_n) begin
            m_act = 1'b0; m_cnt = '0; m_base = '0;
        end else if (!sleep) begin
            if ((!cpu_stb_n && !en1_n) || !ctl_stb_n) begin
                m_base = addr_i;
                m_cnt  = '0;
                m_act  = !en1_n && en2 && !en3_n;
            end else if (m_act) begin
                a = calc_addr(m_base, m_cnt, ilv_order);
                for (int l = 0; l < NL; l++) begin
                    if (!all_wr_n || (!lane_en_n && !lane_wr_n[l])) begin
                        mem_m[a][l*LW +: LW] = din_i[l*LW +: LW];
                        vld[a][l] = 1'b1;
                    end
                end
                if (!step_n) m_cnt = m_cnt + 2'd1;
            end
        end
    endtask

    // Compare drive flag and known lanes of the read data with the model.
    task automatic observe(input string req);
        logic          exp_drv;
        logic [AW-1:0] a;
        logic [WW-1:0] mask;
        exp_drv = m_act && !out_en_n && !sleep;
        chk(drive_o === exp_drv, {req, " drive"}, WW'(drive_o), WW'(exp_drv));
        if (exp_drv) begin
            a = calc_addr(m_base, m_cnt, ilv_order);
            if (vld[a] != '0) begin
                for (int l = 0; l < NL; l++) mask[l*LW +: LW] = {LW{vld[a][l]}};
                chk(((dout_o ^ mem_m[a]) & mask) == '0, {req, " data"},
                    dout_o & mask, mem_m[a] & mask);
            end
        end
    endtask

    task automatic tick(input string req);
        model_edge();
        @(posedge clk);
        #1;
        observe(req);
    endtask

    task automatic quiet();
        cpu_stb_n = 1'b1; ctl_stb_n = 1'b1; step_n = 1'b1;
        all_wr_n = 1'b1; lane_en_n = 1'b1; lane_wr_n = '1;
    endtask

    task automatic start_ctl(input logic [AW-1:0] a, input string req);
        addr_i = a; ctl_stb_n = 1'b0;
        tick(req);
        ctl_stb_n = 1'b1;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #500000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < DEPTH; i++) begin mem_m[i] = '0; vld[i] = '0; end
        m_base = '0; m_cnt = '0; m_act = 1'b0;
        quiet();
        rst_n = 1'b0; sleep = 1'b0; en1_n = 1'b0; en2 = 1'b1; en3_n = 1'b0;
        out_en_n = 1'b0; ilv_order = 1'b1; addr_i = '0; din_i = '0;

        // R1: reset leaves the device deselected.
        tick("R1"); tick("R1");
        rst_n = 1'b1;
        tick("R1");

        // R2 and R9: fill a burst with global writes while stepping.
        start_ctl(8'h40, "R2");
        for (int k = 0; k < 4; k++) begin
            all_wr_n = 1'b0; step_n = 1'b0; din_i = WW'({$urandom, $urandom});
            tick("R9");
        end
        quiet();

        // R5: interleaved order from an odd start.
        start_ctl(8'h41, "R5");
        for (int k = 0; k < 3; k++) begin step_n = 1'b0; tick("R5"); end
        quiet();

        // R6: linear order from the same start.
        ilv_order = 1'b0;
        start_ctl(8'h41, "R6");
        for (int k = 0; k < 3; k++) begin step_n = 1'b0; tick("R6"); end
        quiet();

        // R4: no advance while step_n is high.
        tick("R4"); tick("R4");

        // R7: a single lane write, then lane bits without the lane enable.
        ilv_order = 1'b1;
        start_ctl(8'h40, "R7");
        lane_en_n = 1'b0; lane_wr_n = 4'b1011; din_i = WW'({$urandom, $urandom});
        tick("R7");
        lane_en_n = 1'b1; lane_wr_n = 4'b0000; din_i = ~din_i;
        tick("R7");
        quiet(); tick("R7");

        // R8: global write with every lane select high.
        all_wr_n = 1'b0; lane_en_n = 1'b1; lane_wr_n = '1;
        din_i = WW'({$urandom, $urandom});
        tick("R8");
        quiet(); tick("R8");

        // R13: written word shows at once when the address holds.
        all_wr_n = 1'b0; din_i = WW'({$urandom, $urandom});
        tick("R13");
        quiet(); tick("R13");

        // R10: strobe together with a write request: write ignored.
        addr_i = 8'h43; ctl_stb_n = 1'b0; all_wr_n = 1'b0;
        din_i = WW'({$urandom, $urandom});
        tick("R10");
        quiet(); tick("R10");

        // R3: processor strobe with the first enable high is ignored.
        en1_n = 1'b1; cpu_stb_n = 1'b0; addr_i = 8'h40;
        tick("R3");
        quiet(); en1_n = 1'b0;
        tick("R3");

        // R2: deselect through en2, then a write attempt that must not land.
        en2 = 1'b0;
        start_ctl(8'h40, "R2");
        en2 = 1'b1; all_wr_n = 1'b0; din_i = '1;
        tick("R2");
        quiet();
        start_ctl(8'h40, "R2");

        // R11: output enable acts without a clock edge.
        out_en_n = 1'b1; #1; observe("R11");
        out_en_n = 1'b0; #1; observe("R11");

        // R12: sleep blocks output, writes, strobes and steps.
        sleep = 1'b1; #1; observe("R12");
        all_wr_n = 1'b0; step_n = 1'b0; ctl_stb_n = 1'b0; addr_i = 8'h12;
        din_i = WW'({$urandom, $urandom});
        tick("R12"); tick("R12");
        quiet(); sleep = 1'b0;
        tick("R12");

        // Seeded random traffic checked against the model.
        for (int n = 0; n < 4000; n++) begin
            addr_i    = AW'($urandom);
            din_i     = WW'({$urandom, $urandom});
            ctl_stb_n = ($urandom % 8) != 0;
            cpu_stb_n = ($urandom % 8) != 0;
            en1_n     = ($urandom % 10) == 0;
            en2       = ($urandom % 10) != 0;
            en3_n     = ($urandom % 12) == 0;
            step_n    = ($urandom % 2) != 0;
            all_wr_n  = ($urandom % 5) != 0;
            lane_en_n = ($urandom % 3) == 0;
            lane_wr_n = NL'($urandom);
            out_en_n  = ($urandom % 8) == 0;
            sleep     = ($urandom % 16) == 0;
            if (($urandom % 32) == 0) ilv_order = ~ilv_order;
            tick("R13 random");
        end

        done = 1'b1;
        report();
        $finish;
    end
endmodule